// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides what happens to a small processor's clocks when software executes a sleep instruction. A single strobe `sleep_req` is interpreted through two controls: the idle-enable bit and a two-bit clock-source select. With idle enabled, the CPU stops but the peripherals keep running on whichever source was active before the strobe. With idle disabled and the primary source selected, the block enters full sleep. In full sleep the fast clocks are gated off. Only the watchdog's low-frequency RC and, if wanted, the secondary oscillator stay alive.

Three things end a halted state: an enabled interrupt, a watchdog time-out, or reset. A one-cycle `wake_pulse` marks the wake. `vector_flag` tells the core whether to branch to the interrupt vector or to carry on after the sleep instruction. After a wake from full sleep, the core runs from the internal oscillator while a programmable start-up count elapses. Only when that count ends do the primary clock enable and the oscillator-stable status bit return. Software can poll that bit before it does any timing-critical work.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in full-power run on the primary source. Outputs: `cpu_halt`=0, `pri_clk_en`=1, `int_clk_en`=0, `periph_clk_en`=1, `stat_ost`=1, `stat_intosc`=0, `stat_sosc`=0, `wake_pulse`=0, `vector_flag`=0.
- R2: A `sleep_req` in run with `idle_en`=1 enters idle one cycle later. In idle, `cpu_halt`=1 and `periph_clk_en`=1. The source enables stay those of the source latched at entry, even if `clk_sel` changes later. None of the three status bits changes while idle.
- R3: A `sleep_req` in run with `idle_en`=0 and `clk_sel`=00 enters full sleep one cycle later. In full sleep, `cpu_halt`=1 and `pri_clk_en`, `int_clk_en` and `periph_clk_en` are all 0. `lfrc_clk_en` equals `wdt_en` and `sosc_clk_en` equals `sosc_en`.
- R4: Entering full sleep clears `stat_ost`, `stat_intosc` and `stat_sosc`.
- R5: Two kinds of `sleep_req` are ignored. The first is one in run with `idle_en`=0 and `clk_sel`≠00. The second is any strobe outside run mode.
- R6: Interrupt source i wakes the block only when `irq_flag[i]` and `irq_en[i]` are both 1. Flags whose enable bit is 0 leave the block halted.
- R7: The cycle after an interrupt wake is seen, `wake_pulse` is 1 for exactly one cycle and `cpu_halt` is 0. At that point `vector_flag` equals the `gie` value sampled with the wake. `vector_flag` is cleared on the next entry to a halted state.
- R8: `wdt_timeout` wakes the block from idle or sleep with `vector_flag`=0, and it wins over a simultaneous interrupt. In run mode `wdt_timeout` has no effect.
- R9: A wake from full sleep leads to a start-up phase that lasts `START_CYCLES` cycles. During it, `cpu_halt`=0, `pri_clk_en`=0, `int_clk_en`=1, `stat_ost`=0 and `stat_intosc`=1. On the next cycle the block is back in run with `stat_ost`=1 and the enables of `clk_sel`.
- R10: A wake from idle returns to run on the next cycle with no start-up phase and with `stat_ost` unchanged.
- R11: Reset in any mode, including during the start-up phase, restores the R1 state and clears `vector_flag`.
- R12: In run, the status bits follow `clk_sel` one cycle later. The encoding is 00 = primary, 01 = secondary, 1x = internal. `stat_intosc` is 1 for the internal source and `stat_sosc` is 1 for the secondary source. The enable of the selected source is 1. `sosc_clk_en` is also 1 when `sosc_en` is 1. `lfrc_clk_en` is `wdt_en` OR `int_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| idle_en | input | 1 | Selects idle rather than full sleep |
| clk_sel | input | 2 | Clock source select: 00 primary, 01 secondary, 1x internal |
| wdt_en | input | 1 | Watchdog enabled; keeps the low-frequency RC running |
| sosc_en | input | 1 | Secondary oscillator enable |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out |
| cpu_halt | output | 1 | Stops instruction execution |
| pri_clk_en | output | 1 | Primary oscillator clock enable |
| int_clk_en | output | 1 | Internal fast oscillator enable |
| lfrc_clk_en | output | 1 | Low-frequency RC enable |
| sosc_clk_en | output | 1 | Secondary oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| stat_ost | output | 1 | Primary oscillator start-up complete |
| stat_intosc | output | 1 | Internal oscillator stable |
| stat_sosc | output | 1 | Running from the secondary oscillator |
| wake_pulse | output | 1 | One-cycle wake indication |
| vector_flag | output | 1 | Branch to interrupt vector after wake |

## Verification
The bench builds the block with `N_IRQ`=4 and `START_CYCLES`=12. At that count, every cycle of the start-up phase can be checked, including the last one before `stat_ost` returns, and a reset can land in the middle of it. Four interrupt sources are enough to pair random flag patterns with complementary enable masks, so the bench can show that unenabled flags never wake the block. Each single enabled source can then be driven on its own. Random choices of source select, watchdog and secondary enable, `gie`, and wake cause cover every gating combination in idle and sleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2,
        MODE_WARM  = 2'd3
    } pmc_mode_e;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } pmc_src_e;

    typedef struct packed {
        logic halt;
        logic pri;
        logic intosc;
        logic lfrc;
        logic sosc;
        logic periph;
    } pmc_gate_t;

    typedef struct packed {
        pmc_mode_e mode;
        pmc_src_e  src;
        logic      ost;
        logic      intosc_ok;
        logic      sosc_run;
        logic      wake;
        logic      vec;
    } pmc_state_t;

    function automatic pmc_src_e pmc_decode_src(input logic [1:0] sel);
        if (sel[1])
            return SRC_INT;
        else if (sel[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/pmc_wake_sel.sv
module pmc_wake_sel #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_timeout,
    output logic             wake_req,
    output logic             wake_vec
);

    logic [N_IRQ-1:0] hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign hit[i] = irq_flag[i] & irq_en[i];
    end

    logic irq_any;

    always_comb begin
        irq_any  = |hit;
        wake_req = irq_any | wdt_timeout;
        // watchdog wake never vectors and takes precedence over interrupts
        wake_vec = irq_any & ~wdt_timeout & gie;
    end

endmodule

// File: rtl/pmc_ost_timer.sv
module pmc_ost_timer #(
    parameter int START_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = (START_CYCLES > 1) ? $clog2(START_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(START_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
        done = run && (cnt_q == '0) && !load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pmc_gate_map.sv
module pmc_gate_map
    import pmc_pkg::*;
(
    input  pmc_mode_e mode,
    input  pmc_src_e  src,
    input  logic      wdt_en,
    input  logic      sosc_en,
    output pmc_gate_t gate
);

    always_comb begin
        gate = '0;
        unique case (mode)
            MODE_SLEEP: begin
                gate.halt   = 1'b1;
                gate.pri    = 1'b0;
                gate.intosc = 1'b0;
                gate.lfrc   = wdt_en;
                gate.sosc   = sosc_en;
                gate.periph = 1'b0;
            end
            MODE_WARM: begin
                gate.halt   = 1'b0;
                gate.pri    = 1'b0;
                gate.intosc = 1'b1;
                gate.lfrc   = 1'b1;
                gate.sosc   = sosc_en;
                gate.periph = 1'b1;
            end
            default: begin
                gate.halt   = (mode == MODE_IDLE);
                gate.pri    = (src == SRC_PRI);
                gate.intosc = (src == SRC_INT);
                gate.lfrc   = wdt_en | (src == SRC_INT);
                gate.sosc   = (src == SRC_SEC) | sosc_en;
                gate.periph = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_IRQ        = 8,
    parameter int START_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             idle_en,
    input  logic [1:0]       clk_sel,
    input  logic             wdt_en,
    input  logic             sosc_en,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_timeout,
    output logic             cpu_halt,
    output logic             pri_clk_en,
    output logic             int_clk_en,
    output logic             lfrc_clk_en,
    output logic             sosc_clk_en,
    output logic             periph_clk_en,
    output logic             stat_ost,
    output logic             stat_intosc,
    output logic             stat_sosc,
    output logic             wake_pulse,
    output logic             vector_flag
);

    localparam pmc_state_t RESET_STATE = '{
        mode:      MODE_RUN,
        src:       SRC_PRI,
        ost:       1'b1,
        intosc_ok: 1'b0,
        sosc_run:  1'b0,
        wake:      1'b0,
        vec:       1'b0
    };

    pmc_state_t s_d, s_q;
    logic       wake_req, wake_vec;
    logic       warm_load, warm_done;
    pmc_src_e   sel_src;
    pmc_gate_t  gate;

    pmc_wake_sel #(.N_IRQ(N_IRQ)) u_wake (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .gie         (gie),
        .wdt_timeout (wdt_timeout),
        .wake_req    (wake_req),
        .wake_vec    (wake_vec)
    );

    pmc_ost_timer #(.START_CYCLES(START_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (warm_load),
        .run   (s_q.mode == MODE_WARM),
        .done  (warm_done)
    );

    always_comb begin
        sel_src   = pmc_decode_src(clk_sel);
        s_d       = s_q;
        s_d.wake  = 1'b0;
        warm_load = 1'b0;

        unique case (s_q.mode)
            MODE_RUN: begin
                if (sleep_req && idle_en) begin
                    // keep the source that was active before the strobe
                    s_d.mode = MODE_IDLE;
                    s_d.vec  = 1'b0;
                end else if (sleep_req && (clk_sel == 2'b00)) begin
                    s_d.mode      = MODE_SLEEP;
                    s_d.ost       = 1'b0;
                    s_d.intosc_ok = 1'b0;
                    s_d.sosc_run  = 1'b0;
                    s_d.vec       = 1'b0;
                end else begin
                    s_d.src       = sel_src;
                    s_d.intosc_ok = (sel_src == SRC_INT);
                    s_d.sosc_run  = (sel_src == SRC_SEC);
                end
            end
            MODE_IDLE: begin
                if (wake_req) begin
                    s_d.mode = MODE_RUN;
                    s_d.wake = 1'b1;
                    s_d.vec  = wake_vec;
                end
            end
            MODE_SLEEP: begin
                if (wake_req) begin
                    s_d.mode      = MODE_WARM;
                    s_d.wake      = 1'b1;
                    s_d.vec       = wake_vec;
                    s_d.intosc_ok = 1'b1;
                    warm_load     = 1'b1;
                end
            end
            MODE_WARM: begin
                if (warm_done) begin
                    s_d.mode      = MODE_RUN;
                    s_d.ost       = 1'b1;
                    s_d.src       = sel_src;
                    s_d.intosc_ok = (sel_src == SRC_INT);
                    s_d.sosc_run  = (sel_src == SRC_SEC);
                end
            end
            default: s_d = RESET_STATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= RESET_STATE;
        else
            s_q <= s_d;
    end

    pmc_gate_map u_gate (
        .mode    (s_q.mode),
        .src     (s_q.src),
        .wdt_en  (wdt_en),
        .sosc_en (sosc_en),
        .gate    (gate)
    );

    always_comb begin
        cpu_halt      = gate.halt;
        pri_clk_en    = gate.pri;
        int_clk_en    = gate.intosc;
        lfrc_clk_en   = gate.lfrc;
        sosc_clk_en   = gate.sosc;
        periph_clk_en = gate.periph;
        stat_ost      = s_q.ost;
        stat_intosc   = s_q.intosc_ok;
        stat_sosc     = s_q.sosc_run;
        wake_pulse    = s_q.wake;
        vector_flag   = s_q.vec;
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic clk,
    input logic rst_n,
    input logic wdt_timeout,
    input logic cpu_halt,
    input logic pri_clk_en,
    input logic int_clk_en,
    input logic periph_clk_en,
    input logic stat_ost,
    input logic stat_intosc,
    input logic stat_sosc,
    input logic wake_pulse,
    input logic vector_flag
);

    AST_SLEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !periph_clk_en) |-> (!pri_clk_en && !int_clk_en)); // R3

    AST_SLEEP_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !periph_clk_en) |-> (!stat_ost && !stat_intosc && !stat_sosc)); // R4

    AST_IDLE_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && periph_clk_en && $past(cpu_halt && periph_clk_en))
        |-> $stable({stat_ost, stat_intosc, stat_sosc})); // R2

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R7

    AST_WAKE_RELEASES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !cpu_halt); // R7

    AST_WDT_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && $past(wdt_timeout)) |-> !vector_flag); // R8

    AST_OST_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ost) |-> (!cpu_halt && $past(!cpu_halt))); // R9

    AST_WARM_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && !stat_ost) |-> !pri_clk_en); // R9

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_timeout   (wdt_timeout),
    .cpu_halt      (cpu_halt),
    .pri_clk_en    (pri_clk_en),
    .int_clk_en    (int_clk_en),
    .periph_clk_en (periph_clk_en),
    .stat_ost      (stat_ost),
    .stat_intosc   (stat_intosc),
    .stat_sosc     (stat_sosc),
    .wake_pulse    (wake_pulse),
    .vector_flag   (vector_flag)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

    localparam int NI = 4;
    localparam int SC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0, idle_en = 1'b0;
    logic [1:0]    clk_sel = 2'b00;
    logic          wdt_en = 1'b0, sosc_en = 1'b0;
    logic [NI-1:0] irq_flag = '0, irq_en = '0;
    logic          gie = 1'b0, wdt_timeout = 1'b0;
    logic cpu_halt, pri_clk_en, int_clk_en, lfrc_clk_en, sosc_clk_en, periph_clk_en;
    logic stat_ost, stat_intosc, stat_sosc, wake_pulse, vector_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .START_CYCLES(SC)) u0 (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // mode: 0 run, 1 idle, 2 sleep, 3 start-up; order {halt,pri,int,lfrc,sosc,periph}
    function automatic logic [31:0] exp_gates(input int md, input logic [1:0] sel,
                                              input logic wd, input logic so);
        logic pi, ii, si;
        pi = (sel == 2'b00);
        ii = sel[1];
        si = (sel == 2'b01);
        case (md)
            2:       return {26'd0, 1'b1, 1'b0, 1'b0, wd, so, 1'b0};
            3:       return {26'd0, 1'b0, 1'b0, 1'b1, 1'b1, so, 1'b1};
            default: return {26'd0, (md == 1), pi, ii, wd | ii, si | so, 1'b1};
        endcase
    endfunction

    function automatic logic [31:0] obs_gates();
        return {26'd0, cpu_halt, pri_clk_en, int_clk_en, lfrc_clk_en, sosc_clk_en, periph_clk_en};
    endfunction

    function automatic logic [31:0] obs_stat();
        return {29'd0, stat_ost, stat_intosc, stat_sosc};
    endfunction

    // drive a wake cause; returns expected vector flag
    task automatic drive_wake(output logic exp_vec);
        logic use_wdt;
        logic g;
        int   b;
        use_wdt = 1'($urandom % 2);
        g       = 1'($urandom % 2);
        b       = int'($urandom % NI);
        gie     = g;
        if (use_wdt) begin
            wdt_timeout = 1'b1;
            if ($urandom % 2 == 0) begin
                irq_flag[b] = 1'b1;
                irq_en[b]   = 1'b1;
            end
            exp_vec = 1'b0;
        end else begin
            irq_flag    = '0;
            irq_en      = '0;
            irq_flag[b] = 1'b1;
            irq_en[b]   = 1'b1;
            exp_vec     = g;
        end
    endtask

    task automatic clear_wake();
        wdt_timeout = 1'b0;
        irq_flag    = '0;
        irq_en      = '0;
        gie         = 1'b0;
    endtask

    task automatic masked_irq();
        logic [NI-1:0] f;
        f        = NI'($urandom);
        irq_flag = f;
        irq_en   = ~f;
        step();
        chk("R6 masked flags keep halt", 32'(cpu_halt), 32'd1);
        chk("R6 masked flags no wake", 32'(wake_pulse), 32'd0);
        clear_wake();
    endtask

    task automatic do_idle();
        logic [1:0] s, s2;
        logic       ev;
        logic [31:0] st;
        s        = 2'($urandom);
        clk_sel  = s;
        wdt_en   = 1'($urandom);
        sosc_en  = 1'($urandom);
        step();
        chk("R12 status follows select", obs_stat(), {29'd0, 1'b1, s[1], s == 2'b01});
        chk("R12 run gates", obs_gates(), exp_gates(0, s, wdt_en, sosc_en));
        st        = obs_stat();
        idle_en   = 1'b1;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        idle_en   = 1'($urandom);
        chk("R2 idle gates", obs_gates(), exp_gates(1, s, wdt_en, sosc_en));
        chk("R2 idle status", obs_stat(), st);
        s2      = s ^ (2'd1 + 2'($urandom % 3));
        clk_sel = s2;
        step();
        chk("R2 idle ignores select change", obs_gates(), exp_gates(1, s, wdt_en, sosc_en));
        chk("R2 idle status held", obs_stat(), st);
        masked_irq();
        drive_wake(ev);
        step();
        clear_wake();
        chk("R7 wake pulse", 32'(wake_pulse), 32'd1);
        chk("R7 R8 vector flag", 32'(vector_flag), 32'(ev));
        chk("R10 idle wake direct to run", obs_gates(), exp_gates(0, s, wdt_en, sosc_en));
        chk("R10 ost unchanged", 32'(stat_ost), 32'(st[2]));
        step();
        chk("R7 pulse one cycle", 32'(wake_pulse), 32'd0);
        chk("R12 run follows new select", obs_gates(), exp_gates(0, s2, wdt_en, sosc_en));
    endtask

    task automatic enter_sleep();
        clk_sel = 2'b00;
        wdt_en  = 1'($urandom);
        sosc_en = 1'($urandom);
        step();
        idle_en   = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R3 sleep gates", obs_gates(), exp_gates(2, 2'b00, wdt_en, sosc_en));
        chk("R4 sleep clears status", obs_stat(), 32'd0);
    endtask

    task automatic do_sleep();
        logic ev;
        enter_sleep();
        masked_irq();
        drive_wake(ev);
        step();
        clear_wake();
        chk("R7 wake pulse", 32'(wake_pulse), 32'd1);
        chk("R7 R8 vector flag", 32'(vector_flag), 32'(ev));
        chk("R9 start-up gates", obs_gates(), exp_gates(3, 2'b00, wdt_en, sosc_en));
        chk("R9 start-up status", obs_stat(), {29'd0, 3'b010});
        sleep_req = 1'b1;
        idle_en   = 1'($urandom);
        for (int k = 1; k < SC; k++) begin
            step();
            sleep_req = 1'b0;
            chk("R9 R5 still starting", {30'd0, stat_ost, cpu_halt}, 32'd0);
        end
        step();
        chk("R9 start-up over", 32'(stat_ost), 32'd1);
        chk("R9 primary back", obs_gates(), exp_gates(0, 2'b00, wdt_en, sosc_en));
        chk("R7 vector held", 32'(vector_flag), 32'(ev));
    endtask

    initial begin
        logic ev;
        void'($urandom(32'd20240611));
        step();
        step();
        rst_n = 1'b1;
        step();
        chk("R1 reset gates", obs_gates(), exp_gates(0, 2'b00, 1'b0, 1'b0));
        chk("R1 reset status", obs_stat(), 32'd4);
        chk("R1 reset wake/vec", {30'd0, wake_pulse, vector_flag}, 32'd0);

        // R5: secondary run select with idle disabled ignores the strobe
        clk_sel = 2'b01;
        step();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R5 strobe ignored", 32'(cpu_halt), 32'd0);
        step();
        chk("R5 still running", obs_gates(), exp_gates(0, 2'b01, 1'b0, 1'b0));

        // R8: watchdog time-out in run does nothing
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("R8 run ignores timeout", {30'd0, wake_pulse, cpu_halt}, 32'd0);

        // R8: timeout beats a simultaneous vectored interrupt
        enter_sleep();
        gie = 1'b1; irq_flag = 4'b0001; irq_en = 4'b0001; wdt_timeout = 1'b1;
        step();
        clear_wake();
        chk("R8 timeout priority no vector", {30'd0, wake_pulse, vector_flag}, 32'd2);
        repeat (SC) step();

        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2 == 0) do_idle();
            else do_sleep();
        end

        // R11: reset during start-up with vectored wake pending
        enter_sleep();
        gie = 1'b1; irq_flag = 4'b1000; irq_en = 4'b1000;
        step();
        clear_wake();
        chk("R11 setup vectored wake", 32'(vector_flag), 32'd1);
        step();
        rst_n = 1'b0;
        wdt_en = 1'b0; sosc_en = 1'b0; clk_sel = 2'b00;
        step();
        rst_n = 1'b1;
        step();
        chk("R11 reset gates", obs_gates(), exp_gates(0, 2'b00, 1'b0, 1'b0));
        chk("R11 reset status", obs_stat(), 32'd4);
        chk("R11 vector cleared", {30'd0, wake_pulse, vector_flag}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule